// File: doc/BRIEF.md
# Serial-Input 16-QAM Symbol Mapper

This block turns a serial bit stream, one bit per clock, into a stream of quadrature-amplitude symbols. Four bits are taken for each symbol; a free-running divide-by-four counter marks the clock on which the fourth bit arrives. On that clock the completed nibble goes into a holding register. On the following clock a constellation lookup writes one in-phase (I) and one quadrature (Q) sample into the output registers, and a one-clock valid pulse flags them.

Each output sample is a signed two's-complement word, 8 bits wide by default. It takes one of the four levels +3, +1, -1 or -3, so the 16 symbols form a square 4-by-4 lattice. The first two bits of a group choose the I level and the last two choose the Q level. The mapping from bit pair to level is set by a parameter. The default is a straight ordering. A Gray-ordered variant is available, in which neighbouring levels differ in a single bit. The block sits between a serial data source and a downstream stage such as pulse shaping or a converter interface.

Top module: `qam16_serial_mapper`

## Requirements
- R1: While `rst` is 1, and on the first clock after it falls, `sym_valid` is 0 and `i_sample` and `q_sample` are 0.
- R2: After reset, on a continuous bit stream, `sym_valid` is high for exactly one clock in every four clocks.
- R3: Bits are grouped in arrival order, and the first bit of a group is the nibble MSB (bit 3). Nibble bits [3:2] select I and bits [1:0] select Q.
- R4: In the default mapping, bit pair 00 gives +3, 01 gives +1, 10 gives -1 and 11 gives -3. Levels are 8-bit two's complement: +3 = 00000011, +1 = 00000001, -1 = 11111111, -3 = 11111101. For example, nibble 1111 gives I = Q = -3, and nibble 1110 gives I = -3 and Q = -1.
- R5: The bit sampled on the 4th, 8th, 12th, ... rising edge after reset completes a group. The I/Q result and `sym_valid` appear after the next rising edge, so `sym_valid` is first seen after edge 5, then after edges 9, 13, and so on.
- R6: `i_sample` and `q_sample` keep their value on every clock on which `sym_valid` is 0.
- R7: Whenever `sym_valid` is 1, both samples are odd and lie within -3 to +3.
- R8: A reset during a partially received group discards those bits. The first four bits after reset form the next symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit is sampled on each rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data bit |
| sym_valid | output | 1 | One-clock pulse marking a new I/Q pair |
| i_sample | output | 8 | In-phase level, signed two's complement |
| q_sample | output | 8 | Quadrature level, signed two's complement |

## Verification
The embedded assertions check four properties on every clock. The symbol strobe and the valid pulse are never wider than one clock. A loaded nibble always yields a valid pulse on the next clock. The outputs never move between pulses. Every pulsed sample is a legal odd level within range. Only the scoreboard scenarios can show the correctness of the actual level values, the MSB-first bit order, the I/Q split, the exact pulse phase relative to reset, and the discarding of a partial group when reset arrives mid-symbol.

// File: rtl/qam16_pkg.sv
package qam16_pkg;

   // Selects how an axis bit pair is ranked onto the amplitude ladder.
   typedef enum logic {
      LVL_ORDER_STRAIGHT = 1'b0,
      LVL_ORDER_GRAY     = 1'b1
   } lvl_order_e;

   // Largest magnitude on an axis with the given number of code bits.
   function automatic int unsigned axis_peak(input int unsigned code_bits);
      return (1 << code_bits) - 1;
   endfunction

endpackage : qam16_pkg

// File: rtl/sym_strobe_div.sv
module sym_strobe_div #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst,
   output logic strobe
);
   localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("sym_strobe_div: DIV must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign strobe = !rst && (cnt_q == LAST);

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe) else $error("strobe wider than one clock"); // R2

endmodule : sym_strobe_div

// File: rtl/ser2par_shift.sv
module ser2par_shift #(
   parameter int unsigned WORD_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word_now
);
   generate
      if (WORD_W < 2) begin : g_bad_w
         $error("ser2par_shift: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-2:0] sh_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q <= '0;
      end else begin
         sh_q <= {sh_q[WORD_W-3 >= 0 ? WORD_W-3 : 0 : 0], bit_in} ;
      end
   end

   // Word completed by the bit currently on the input; earliest bit is MSB.
   assign word_now = {sh_q, bit_in};

endmodule : ser2par_shift

// File: rtl/sym_hold_reg.sv
module sym_hold_reg #(
   parameter int unsigned WORD_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] word_q,
   output logic              fresh_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         word_q  <= '0;
         fresh_q <= 1'b0;
      end else begin
         fresh_q <= load;
         if (load) begin
            word_q <= word_in;
         end
      end
   end

endmodule : sym_hold_reg

// File: rtl/axis_level_map.sv
module axis_level_map
   import qam16_pkg::*;
#(
   parameter int unsigned CODE_W   = 2,
   parameter int unsigned SAMPLE_W = 8,
   parameter lvl_order_e  ORDER    = LVL_ORDER_STRAIGHT
) (
   input  logic [CODE_W-1:0]   code,
   output logic [SAMPLE_W-1:0] level
);
   localparam logic [SAMPLE_W-1:0] PEAK = SAMPLE_W'(axis_peak(CODE_W));

   generate
      if (SAMPLE_W < CODE_W + 2) begin : g_bad_sw
         $error("axis_level_map: SAMPLE_W too small for the level range");
      end
   endgenerate

   logic [CODE_W-1:0] rank;

   generate
      if (ORDER == LVL_ORDER_GRAY) begin : g_gray
         always_comb begin
            rank[CODE_W-1] = code[CODE_W-1];
            for (int k = CODE_W - 2; k >= 0; k--) begin
               rank[k] = rank[k+1] ^ code[k];
            end
         end
      end else begin : g_straight
         assign rank = code;
      end
   endgenerate

   // Rank 0 is the top level; each step down the ladder subtracts two.
   assign level = PEAK - (SAMPLE_W'(rank) << 1);

endmodule : axis_level_map

// File: rtl/qam16_serial_mapper.sv
module qam16_serial_mapper
   import qam16_pkg::*;
#(
   parameter int unsigned AXIS_BITS = 2,
   parameter int unsigned SAMPLE_W  = 8,
   parameter lvl_order_e  ORDER     = LVL_ORDER_STRAIGHT
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ser_in,
   output logic                sym_valid,
   output logic [SAMPLE_W-1:0] i_sample,
   output logic [SAMPLE_W-1:0] q_sample
);
   localparam int unsigned SYM_BITS = 2 * AXIS_BITS;
   localparam int          PEAK_I   = int'(axis_peak(AXIS_BITS));

   generate
      if (AXIS_BITS < 1) begin : g_bad_axis
         $error("qam16_serial_mapper: AXIS_BITS must be at least 1");
      end
   endgenerate

   logic                strobe;
   logic [SYM_BITS-1:0] word_now;
   logic [SYM_BITS-1:0] word_held;
   logic                held_fresh;
   logic [SAMPLE_W-1:0] i_lvl;
   logic [SAMPLE_W-1:0] q_lvl;

   sym_strobe_div #(.DIV(SYM_BITS)) u_div (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe)
   );

   ser2par_shift #(.WORD_W(SYM_BITS)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .bit_in   (ser_in),
      .word_now (word_now)
   );

   sym_hold_reg #(.WORD_W(SYM_BITS)) u_hold (
      .clk     (clk),
      .rst     (rst),
      .load    (strobe),
      .word_in (word_now),
      .word_q  (word_held),
      .fresh_q (held_fresh)
   );

   axis_level_map #(.CODE_W(AXIS_BITS), .SAMPLE_W(SAMPLE_W), .ORDER(ORDER)) u_map_i (
      .code  (word_held[SYM_BITS-1 -: AXIS_BITS]),
      .level (i_lvl)
   );

   axis_level_map #(.CODE_W(AXIS_BITS), .SAMPLE_W(SAMPLE_W), .ORDER(ORDER)) u_map_q (
      .code  (word_held[AXIS_BITS-1:0]),
      .level (q_lvl)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sym_valid <= 1'b0;
         i_sample  <= '0;
         q_sample  <= '0;
      end else begin
         sym_valid <= held_fresh;
         if (held_fresh) begin
            i_sample <= i_lvl;
            q_sample <= q_lvl;
         end
      end
   end

   AST_LOAD_TO_VALID: assert property (@(posedge clk) disable iff (rst)
      strobe |=> ##1 sym_valid) else $error("valid missing after load"); // R5

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
      sym_valid |=> !sym_valid) else $error("valid wider than one clock"); // R2

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
      !sym_valid |-> ($stable(i_sample) && $stable(q_sample))) else $error("samples moved"); // R6

   AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
      sym_valid |-> (i_sample[0] && q_sample[0]
                     && $signed(i_sample) <= PEAK_I && $signed(i_sample) >= -PEAK_I
                     && $signed(q_sample) <= PEAK_I && $signed(q_sample) >= -PEAK_I))
      else $error("illegal level"); // R7

endmodule : qam16_serial_mapper

// File: tb/qam16_serial_mapper_tb.sv
`timescale 1ns/1ps
module qam16_serial_mapper_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ser_in = 1'b0;
   logic       sym_valid;
   logic [7:0] i_sample;
   logic [7:0] q_sample;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit mon_en = 1'b0;
   bit finished = 1'b0;
   logic [15:0] exp_q[$];
   logic [7:0]  last_i, last_q;

   always #10 clk = ~clk;

   qam16_serial_mapper u_dut (
      .clk(clk), .rst(rst), .ser_in(ser_in),
      .sym_valid(sym_valid), .i_sample(i_sample), .q_sample(q_sample)
   );

   function automatic logic [7:0] lvl(input logic [1:0] c);
      case (c)
         2'b00:   return 8'sd3;
         2'b01:   return 8'sd1;
         2'b10:   return -8'sd1;
         default: return -8'sd3;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic send_sym(input logic [3:0] nib);
      exp_q.push_back({lvl(nib[3:2]), lvl(nib[1:0])});
      for (int b = 3; b >= 0; b--) begin
         ser_in = nib[b];
         @(negedge clk);
      end
   endtask

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (mon_en && !rst) begin
         if (sym_valid) begin
            chk((cyc % 4 == 1) && cyc >= 5, "R5/R2 pulse phase", cyc, 5);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected symbol", {i_sample, q_sample}, 0);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk({i_sample, q_sample} === e, "R3/R4 I/Q levels", {i_sample, q_sample}, e);
            end
         end else begin
            chk(i_sample === last_i && q_sample === last_q, "R6 hold", {i_sample, q_sample}, {last_i, last_q});
         end
      end
      last_i = i_sample;
      last_q = q_sample;
   end

   task automatic do_reset();
      ser_in = 1'b0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(sym_valid === 1'b0 && i_sample === 8'h00 && q_sample === 8'h00,
          "R1 reset state", {sym_valid, i_sample, q_sample}, 0);
      rst = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk);
      @(negedge clk);
      mon_en = 1'b0;
      chk(exp_q.size() == 0, "R5 all symbols seen", exp_q.size(), 0);
   endtask

   initial begin
      #(20ns * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      mon_en = 1'b1;
      @(negedge clk);
      chk(sym_valid === 1'b0 && i_sample === 8'h00, "R1 after release", {sym_valid, i_sample}, 0);
      exp_q.delete();
      // The first negedge after release already consumed a bit slot; restart cleanly.
      do_reset();
      mon_en = 1'b1;
      // R4 stated examples
      send_sym(4'b1111);   // R4: I=Q=11111101
      send_sym(4'b1110);   // R4: I=11111101, Q=11111111
      // R3 all 16 nibbles, MSB first, I from upper pair
      for (int n = 0; n < 16; n++) send_sym(4'(n));
      drain();
      // R8 reset mid-symbol: two stray bits then reset
      ser_in = 1'b1; @(negedge clk);
      ser_in = 1'b1; @(negedge clk);
      do_reset();
      mon_en = 1'b1;
      send_sym(4'b0001);
      send_sym(4'b1000);
      send_sym(4'b0110);
      drain();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule : qam16_serial_mapper_tb